// File: doc/BRIEF.md
# SGI Group-Matching Delivery

This block sits in front of one processor's interrupt redistributor and turns software-generated interrupt requests into pending state. Each request names one of the sixteen software interrupt IDs and states the group the sender believes the interrupt belongs to. For every ID, the receiver holds two configuration bits: a group bit and a modifier bit. Together they say which group that ID is expected to arrive in.

A request whose stated group equals the ID's expected group raises that ID's pending bit. A request that does not match is discarded. A discarded request changes no pending state. It is reported only on a one-cycle drop pulse and in a saturating drop counter.

A small register port gives plain read/write access to the group and modifier vectors. It also gives separate write-1-to-set and write-1-to-clear views of the pending vector, so software can raise or retire interrupts by hand.

Top module: `sgi_delivery`

## Requirements
- R1: After a synchronous reset, the pending vector, the group and modifier vectors, the drop counter and the drop pulse are all zero, and every register address reads zero.
- R2: Each request selects exactly one ID in 0..NUM_ID-1 (16 by default). An accepted request raises at most that one pending bit.
- R3: The expected group of an ID is decoded from (group bit, modifier bit) as follows: (0,0) is Group 0, (0,1) is Secure Group 1, and both (1,0) and (1,1) are Non-Secure Group 1. The sender group code is 0 for Group 0, 1 for Secure Group 1 and 2 for Non-Secure Group 1. Code 3 never matches.
- R4: A matching request sets pending[id], and the bit reads 1 from the cycle after the request. A request for an ID that is already pending leaves it pending, with no second record.
- R5: A non-matching request leaves the pending vector unchanged. This includes Non-Secure Group 1 sent to a Secure Group 1 ID, and the reverse case.
- R6: Each dropped request drives drop_pulse high for the following cycle only. It also increments drop_count by one, and drop_count holds at 2^CNT_W-1 once it reaches that value.
- R7: The register map is:
  - address 0: group vector, read/write.
  - address 1: modifier vector, read/write.
  - address 2: write 1 to set pending bits.
  - address 3: write 1 to clear pending bits.
  - Addresses 2 and 3 both read back the pending vector.
  - Addresses 4 to 7 read zero, and writes to them have no effect.
- R8: When a request and a software clear hit the same ID in the same cycle, the ID ends up pending. A software set and clear of the same bit also leave it set.
- R9: A request that arrives in the same cycle as a configuration write is matched against the configuration from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_id | input | $clog2(NUM_ID) | Target interrupt ID |
| req_group | input | 2 | Sender's stated group code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NUM_ID | Register write data |
| reg_rdata | output | NUM_ID | Register read data (combinational) |
| pending | output | NUM_ID | Pending vector |
| drop_pulse | output | 1 | One-cycle indication of a discarded request |
| drop_count | output | CNT_W | Saturating count of discarded requests |

## Verification
The bench keeps NUM_ID at 16, so all sixteen IDs and every pairing of configuration with sender code are exercised. It sets CNT_W to 4, so the drop counter saturates at 15 within a few hundred random cycles. A directed burst of drops then checks that the counter holds at that value. The random phase mixes requests with writes to all eight addresses. This makes collisions between requests, clears and configuration writes occur many times.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    typedef enum logic [1:0] {
        SRC_G0   = 2'd0,
        SRC_SG1  = 2'd1,
        SRC_NSG1 = 2'd2,
        SRC_BAD  = 2'd3
    } src_grp_e;

    typedef struct packed {
        logic accept;
        logic drop;
    } verdict_t;

    localparam logic [2:0] ADDR_GROUP = 3'd0;
    localparam logic [2:0] ADDR_MODIF = 3'd1;
    localparam logic [2:0] ADDR_PSET  = 3'd2;
    localparam logic [2:0] ADDR_PCLR  = 3'd3;

    function automatic src_grp_e expected_grp(input logic grp_bit, input logic mod_bit);
        src_grp_e r;
        case ({grp_bit, mod_bit})
            2'b00:   r = SRC_G0;
            2'b01:   r = SRC_SG1;
            default: r = SRC_NSG1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sgi_cfg_regs.sv
module sgi_cfg_regs #(
    parameter int NUM_ID = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [NUM_ID-1:0] wdata,
    output logic [NUM_ID-1:0] grp_q,
    output logic [NUM_ID-1:0] mod_q
);
    import sgi_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
            mod_q <= '0;
        end else if (we) begin
            if (addr == ADDR_GROUP) grp_q <= wdata;
            if (addr == ADDR_MODIF) mod_q <= wdata;
        end
    end

endmodule

// File: rtl/sgi_match.sv
module sgi_match #(
    parameter int NUM_ID = 16,
    parameter int ID_W   = $clog2(NUM_ID)
) (
    input  logic                req_valid,
    input  logic [ID_W-1:0]     req_id,
    input  sgi_pkg::src_grp_e   req_grp,
    input  logic [NUM_ID-1:0]   grp_q,
    input  logic [NUM_ID-1:0]   mod_q,
    output sgi_pkg::verdict_t   verdict,
    output logic [NUM_ID-1:0]   hit_vec
);
    import sgi_pkg::*;

    localparam logic [ID_W:0] ID_LIMIT = NUM_ID[ID_W:0];

    logic     in_range;
    src_grp_e want;

    always_comb begin
        in_range       = ({1'b0, req_id} < ID_LIMIT);
        want           = in_range ? expected_grp(grp_q[req_id], mod_q[req_id]) : SRC_BAD;
        verdict.accept = req_valid && in_range && (req_grp == want);
        verdict.drop   = req_valid && !verdict.accept;
        hit_vec        = '0;
        if (verdict.accept) hit_vec[req_id] = 1'b1;
    end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
    parameter int NUM_ID = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_ID-1:0] req_set,
    input  logic [NUM_ID-1:0] sw_set,
    input  logic [NUM_ID-1:0] sw_clr,
    output logic [NUM_ID-1:0] pend
);

    for (genvar i = 0; i < NUM_ID; i++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= (bit_q & ~sw_clr[i]) | sw_set[i] | req_set[i];
        end

        assign pend[i] = bit_q;

        AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
            req_set[i] |=> pend[i]); // R4
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
            (!req_set[i] && !sw_set[i] && !pend[i]) |=> !pend[i]); // R5
        AST_REQ_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
            (req_set[i] && sw_clr[i]) |=> pend[i]); // R8
    end

endmodule

// File: rtl/sgi_delivery.sv
module sgi_delivery #(
    parameter int NUM_ID = 16,
    parameter int CNT_W  = 16,
    parameter int ID_W   = $clog2(NUM_ID)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [1:0]        req_group,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [NUM_ID-1:0] reg_wdata,
    output logic [NUM_ID-1:0] reg_rdata,
    output logic [NUM_ID-1:0] pending,
    output logic              drop_pulse,
    output logic [CNT_W-1:0]  drop_count
);
    import sgi_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_ID-1:0] grp_q, mod_q, hit_vec, sw_set, sw_clr;
    verdict_t          verdict;

    sgi_cfg_regs #(.NUM_ID(NUM_ID)) u_cfg (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .grp_q(grp_q), .mod_q(mod_q)
    );

    sgi_match #(.NUM_ID(NUM_ID), .ID_W(ID_W)) u_match (
        .req_valid(req_valid), .req_id(req_id), .req_grp(src_grp_e'(req_group)),
        .grp_q(grp_q), .mod_q(mod_q), .verdict(verdict), .hit_vec(hit_vec)
    );

    always_comb begin
        sw_set = (reg_we && reg_addr == ADDR_PSET) ? reg_wdata : '0;
        sw_clr = (reg_we && reg_addr == ADDR_PCLR) ? reg_wdata : '0;
    end

    sgi_pend_bank #(.NUM_ID(NUM_ID)) u_pend (
        .clk(clk), .rst(rst), .req_set(hit_vec), .sw_set(sw_set), .sw_clr(sw_clr),
        .pend(pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_pulse <= 1'b0;
            drop_count <= '0;
        end else begin
            drop_pulse <= verdict.drop;
            if (verdict.drop && drop_count != CNT_MAX) drop_count <= drop_count + 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_GROUP:          reg_rdata = grp_q;
            ADDR_MODIF:          reg_rdata = mod_q;
            ADDR_PSET, ADDR_PCLR: reg_rdata = pending;
            default:             reg_rdata = '0;
        endcase
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (drop_pulse && $past(drop_count) != CNT_MAX) |-> drop_count == CNT_W'($past(drop_count) + 1'b1)); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !drop_pulse |-> $stable(drop_count)); // R6
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        ($past(drop_count) == CNT_MAX) |-> drop_count == CNT_MAX); // R6

endmodule

// File: tb/test_sgi_delivery.sv
module test_sgi_delivery;

    localparam int N  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    req_id = '0;
    logic [1:0]    req_group = '0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata, pending;
    logic          drop_pulse;
    logic [CW-1:0] drop_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [N-1:0]  m_grp = '0, m_mod = '0, m_pend = '0;
    int            m_cnt = 0;
    logic          m_pulse = 1'b0;

    always #5 clk = ~clk;

    sgi_delivery #(.NUM_ID(N), .CNT_W(CW)) i_sgi_delivery (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_group(req_group),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pending(pending), .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    function automatic logic [1:0] want_code(input logic g, input logic m);
        if (g) return 2'd2;
        return m ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [N-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_grp;
            3'd1: return m_mod;
            3'd2, 3'd3: return m_pend;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input string tag, input logic rv, input logic [3:0] id, input logic [1:0] g,
                         input logic we, input logic [2:0] a, input logic [N-1:0] wd);
        logic acc;
        logic [N-1:0] s, c;
        @(negedge clk);
        req_valid = rv; req_id = id; req_group = g;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        acc = rv && (g == want_code(m_grp[id], m_mod[id]));
        s = (we && a == 3'd2) ? wd : '0;
        c = (we && a == 3'd3) ? wd : '0;
        m_pend = (m_pend & ~c) | s | (acc ? (N'(1) << id) : '0);
        if (we && a == 3'd0) m_grp = wd;
        if (we && a == 3'd1) m_mod = wd;
        m_pulse = rv && !acc;
        if (m_pulse && m_cnt != (1 << CW) - 1) m_cnt++;
        @(posedge clk);
        #1;
        req_valid = 1'b0; reg_we = 1'b0;
        chk({tag, " pending"}, 32'(pending), 32'(m_pend));
        chk({tag, " drop_pulse"}, 32'(drop_pulse), 32'(m_pulse));
        chk({tag, " drop_count"}, 32'(drop_count), 32'(m_cnt));
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        reg_addr = a;
        #1;
        chk(tag, 32'(reg_rdata), 32'(model_read(a)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 reset pending", 32'(pending), 0);
        chk("R1 reset pulse", 32'(drop_pulse), 0);
        chk("R1 reset count", 32'(drop_count), 0);
        for (int a = 0; a < 8; a++) rd("R1 reset read", 3'(a));

        // ID5 -> NSG1 (1,0), ID6 -> SG1 (0,1), ID7 -> reserved (1,1) as NSG1
        cycle("R7 group write", 0, 0, 0, 1, 3'd0, 16'h00A0);
        cycle("R7 modifier write", 0, 0, 0, 1, 3'd1, 16'h00C0);
        rd("R7 group read", 3'd0);
        rd("R7 modifier read", 3'd1);
        cycle("R5 SG1 to NSG1 id dropped", 1, 4'd5, 2'd1, 0, 0, 0);
        cycle("R5 NSG1 to SG1 id dropped", 1, 4'd6, 2'd2, 0, 0, 0);
        cycle("R4 SG1 accepted", 1, 4'd6, 2'd1, 0, 0, 0);
        cycle("R3 reserved pair as NSG1", 1, 4'd7, 2'd2, 0, 0, 0);
        cycle("R3 code 3 never matches", 1, 4'd0, 2'd3, 0, 0, 0);
        cycle("R2 G0 on id0", 1, 4'd0, 2'd0, 0, 0, 0);
        cycle("R4 merge repeat", 1, 4'd0, 2'd0, 0, 0, 0);
        cycle("R8 request beats clear", 1, 4'd6, 2'd1, 1, 3'd3, 16'hFFFF);
        cycle("R8 set beats clear", 0, 0, 0, 1, 3'd2, 16'h0300);
        cycle("R7 clear view", 0, 0, 0, 1, 3'd3, 16'h0100);
        rd("R7 pending read set view", 3'd2);
        rd("R7 pending read clear view", 3'd3);
        cycle("R7 unmapped write ignored", 0, 0, 0, 1, 3'd5, 16'hFFFF);
        rd("R7 unmapped read zero", 3'd5);
        rd("R7 group intact", 3'd0);
        cycle("R9 old config used", 1, 4'd1, 2'd2, 1, 3'd0, 16'h00A2);
        cycle("R9 new config used", 1, 4'd1, 2'd2, 0, 0, 0);

        for (int k = 0; k < 600; k++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 7));
            cycle("R4 random", 1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)),
                  2'($urandom_range(0, 3)), 1'($urandom_range(0, 4) == 0), a, N'($urandom));
            rd("R7 random read", 3'($urandom_range(0, 7)));
        end

        for (int k = 0; k < 20; k++) cycle("R6 saturate", 1, 4'd2, 2'd3, 0, 0, 0);
        chk("R6 count held at max", 32'(drop_count), 32'((1 << CW) - 1));
        cycle("R6 pulse falls", 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule